// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block predicts where a control instruction will send fetch in a five-stage pipeline that always executes the single instruction after a control instruction (the delay slot). When a control instruction reaches the decode stage, its address selects one row of a small direct-mapped table. If that row holds a target, the block presents it at once, and the fetch unit uses it as the fetch address on the following cycle. If the row is empty, the block holds fetch until the real target is known.

When the pipeline resolves the control instruction, it reports the instruction's address, whether it was taken and the taken target. The block writes the resolved target into the row for that address. It then compares the target with the guess it handed out. A correct guess causes no disturbance. A wrong guess produces a redirect to the resolved target and a squash request. The squash request carries the number of wrong-path fetches to kill, counted from the cycle after the lookup, so the delay-slot instruction is never part of it. A not-taken instruction records its fall-through address, which is the instruction address plus 8 because of the delay slot.

Top module: `btb_direct`

## Requirements
- R1: The table has 16 rows and is direct mapped. The row is selected by address bits [5:2]. Addresses that agree in those bits share a row, and addresses that differ in them use separate rows.
- R2: When `lk_valid` is high and the selected row is filled, `pred_hit` is 1 in the same cycle and `pred_target` equals the stored target.
- R3: When `upd_valid` is high, the row selected by `upd_pc` is written at the clock edge. The stored value is `upd_target` if `upd_taken` is 1, otherwise `upd_pc + 8`. A lookup in any later cycle returns the new value. Targets are word aligned.
- R4: If a lookup and an update select the same row in the same cycle, the lookup returns the row's contents from before the write.
- R5: When a lookup hit is resolved to the same target that was predicted, `redirect_valid` and `squash_valid` both stay 0.
- R6: When a lookup hit is resolved to a different target, the resolution cycle shows `redirect_valid` = 1, `redirect_pc` = the resolved target and `squash_valid` = 1. `squash_cnt` equals the number of cycles from the lookup to the resolution (1 when the resolution comes in the cycle right after the lookup), saturating at 7. This count excludes the delay-slot instruction.
- R7: A lookup of an empty row gives `pred_hit` = 0. `fetch_hold` is then 1 from the next cycle through the resolution cycle. Resolution gives `redirect_valid` = 1 with the resolved target and `squash_valid` = 0.
- R8: Reset empties every row. After reset, `fetch_hold`, `redirect_valid` and `squash_valid` are 0.
- R9: While `lk_valid` is 0, `pred_hit` is 0 and `pred_target` is 0.
- R10: `redirect_valid` and `squash_valid` are 1 only in a cycle with `upd_valid` = 1 while a lookup is outstanding. An update with nothing outstanding only writes the table. A new lookup replaces the outstanding one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A control instruction is in the decode stage |
| lk_pc | input | 32 | Address of that control instruction |
| pred_hit | output | 1 | Predicted target is available this cycle |
| pred_target | output | 32 | Predicted fetch address for the next cycle |
| upd_valid | input | 1 | A control instruction resolves this cycle |
| upd_pc | input | 32 | Address of the resolving instruction |
| upd_taken | input | 1 | The resolving instruction was taken |
| upd_target | input | 32 | Taken target of the resolving instruction |
| fetch_hold | output | 1 | Fetch must wait for resolution (empty row was looked up) |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Resolved fetch address |
| squash_valid | output | 1 | Wrong-path instructions must be killed |
| squash_cnt | output | 3 | Number of wrong-path fetches after the delay slot |

## Verification
Several properties are checked on every cycle. The row is empty on the first cycle after reset. A write is visible to a lookup of the same row on the next cycle. `fetch_hold` rises only after a lookup of an empty row and drops after a resolution that brings no new lookup. A squash always carries a nonzero count, and a hit that resolves to its own guess never squashes. Other behaviours can only be shown by the bench's scenarios, because they depend on histories longer than a few cycles. These are aliasing between addresses that share index bits, the not-taken fall-through value, the old-data result of a same-cycle lookup and write, and saturation of the squash count on slow resolutions. The bench compares them against a reference table it keeps itself.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Bytes from a control instruction to the first instruction after its delay slot
   localparam int unsigned SLOT_BYTES = 8;

   // Outcome of a resolution against the outstanding lookup
   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_MATCH = 2'd1,
      RES_FILL  = 2'd2,
      RES_WRONG = 2'd3
   } res_kind_e;

endpackage

// File: rtl/btb_index.sv
module btb_index #(
   parameter int ADDR_W  = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 4
) (
   input  logic [ADDR_W-1:0] pc,
   output logic [IDX_W-1:0]  idx
);

   assign idx = pc[IDX_LSB +: IDX_W];

   // bits outside the index field do not select a row
   logic unused_bits;
   assign unused_bits = ^{pc[ADDR_W-1:IDX_LSB+IDX_W], pc[IDX_LSB-1:0]};

endmodule

// File: rtl/btb_table.sv
module btb_table #(
   parameter int ADDR_W      = 32,
   parameter int ENTRIES     = 16,
   parameter int IDX_LSB     = 2,
   parameter bit COMPACT_TGT = 1'b1,
   localparam int IDX_W      = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_hit,
   output logic [ADDR_W-1:0] rd_tgt,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_tgt
);

   localparam int SLSB = COMPACT_TGT ? IDX_LSB : 0;
   localparam int SW   = ADDR_W - SLSB;

   logic [ENTRIES-1:0] vld_w;
   logic [SW-1:0]      tgt_w [ENTRIES];
   logic [SW-1:0]      rd_store;

   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_row
      logic          vld_q;
      logic [SW-1:0] tgt_q;
      logic          sel;

      assign sel = wr_en && (wr_idx == IDX_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q <= 1'b0;
         else if (sel) vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) tgt_q <= wr_tgt[ADDR_W-1:SLSB];
      end

      assign vld_w[gi] = vld_q;
      assign tgt_w[gi] = tgt_q;
   end

   // read sees the contents before any write at the coming edge (old data)
   assign rd_hit   = vld_w[rd_idx];
   assign rd_store = tgt_w[rd_idx];

   if (COMPACT_TGT) begin : g_compact
      assign rd_tgt = {rd_store, {SLSB{1'b0}}};

      logic unused_low;
      assign unused_low = ^wr_tgt[SLSB-1:0];

      AST_ALIGNED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> (wr_tgt[SLSB-1:0] == '0)); // R3
   end else begin : g_full
      assign rd_tgt = rd_store;
   end

   AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && (rd_idx == $past(wr_idx)))
      |-> (rd_hit && (rd_tgt[ADDR_W-1:IDX_LSB] == $past(wr_tgt[ADDR_W-1:IDX_LSB])))); // R3

   AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !rd_hit); // R8

endmodule

// File: rtl/btb_tracker.sv
module btb_tracker
   import btb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic              lk_hit,
   input  logic [ADDR_W-1:0] lk_tgt,
   input  logic              up_en,
   input  logic [ADDR_W-1:0] up_res,
   output logic              fetch_hold,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic              squash_valid,
   output logic [CNT_W-1:0]  squash_cnt
);

   localparam logic [CNT_W-1:0] AGE_MAX = {CNT_W{1'b1}};

   logic              pend_q;
   logic              hit_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [CNT_W-1:0]  age_q;
   res_kind_e         kind;

   always_comb begin
      kind = RES_NONE;
      if (up_en && pend_q) begin
         if (!hit_q)               kind = RES_FILL;
         else if (up_res == tgt_q) kind = RES_MATCH;
         else                      kind = RES_WRONG;
      end
   end

   // one outstanding lookup; a new lookup supersedes the old record
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         hit_q  <= 1'b0;
         tgt_q  <= '0;
         age_q  <= '0;
      end else if (lk_en) begin
         pend_q <= 1'b1;
         hit_q  <= lk_hit;
         tgt_q  <= lk_tgt;
         age_q  <= CNT_W'(1);
      end else if (up_en) begin
         pend_q <= 1'b0;
         age_q  <= '0;
      end else if (pend_q && (age_q != AGE_MAX)) begin
         age_q  <= age_q + 1'b1;
      end
   end

   assign fetch_hold     = pend_q && !hit_q;
   assign redirect_valid = (kind == RES_FILL) || (kind == RES_WRONG);
   assign redirect_pc    = up_res;
   assign squash_valid   = (kind == RES_WRONG);
   assign squash_cnt     = (kind == RES_WRONG) ? age_q : '0;

   AST_HOLD_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_hold) |-> $past(lk_en && !lk_hit)); // R7

   AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_hold && up_en && !lk_en) |=> !fetch_hold); // R7

   AST_SQUASH_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |-> (squash_cnt != '0)); // R6

   AST_CORRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(lk_en && lk_hit) && up_en && (up_res == $past(lk_tgt)))
      |-> (!squash_valid && !redirect_valid)); // R5

endmodule

// File: rtl/btb_direct.sv
module btb_direct #(
   parameter int ADDR_W      = 32,
   parameter int ENTRIES     = 16,
   parameter int IDX_LSB     = 2,
   parameter int CNT_W       = 3,
   parameter bit COMPACT_TGT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              pred_hit,
   output logic [ADDR_W-1:0] pred_target,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   output logic              fetch_hold,
   output logic              redirect_valid,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic              squash_valid,
   output logic [CNT_W-1:0]  squash_cnt
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_chk_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (IDX_LSB < 1) begin : g_chk_lsb
      $error("IDX_LSB must be at least 1");
   end
   if (ADDR_W <= IDX_LSB + IDX_W) begin : g_chk_addr
      $error("ADDR_W too small for the index field");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [IDX_W-1:0]  up_idx;
   logic              tbl_hit;
   logic [ADDR_W-1:0] tbl_tgt;
   logic [ADDR_W-1:0] upd_resolved;

   btb_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_idx (
      .pc  (lk_pc),
      .idx (lk_idx)
   );

   btb_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_up_idx (
      .pc  (upd_pc),
      .idx (up_idx)
   );

   // a not-taken instruction continues after its delay slot
   assign upd_resolved = upd_taken ? upd_target
                                   : upd_pc + ADDR_W'(btb_pkg::SLOT_BYTES);

   btb_table #(
      .ADDR_W      (ADDR_W),
      .ENTRIES     (ENTRIES),
      .IDX_LSB     (IDX_LSB),
      .COMPACT_TGT (COMPACT_TGT)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_hit (tbl_hit),
      .rd_tgt (tbl_tgt),
      .wr_en  (upd_valid),
      .wr_idx (up_idx),
      .wr_tgt (upd_resolved)
   );

   assign pred_hit    = lk_valid && tbl_hit;
   assign pred_target = pred_hit ? tbl_tgt : '0;

   btb_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tracker (
      .clk            (clk),
      .rst_n          (rst_n),
      .lk_en          (lk_valid),
      .lk_hit         (pred_hit),
      .lk_tgt         (pred_target),
      .up_en          (upd_valid),
      .up_res         (upd_resolved),
      .fetch_hold     (fetch_hold),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .squash_valid   (squash_valid),
      .squash_cnt     (squash_cnt)
   );

endmodule

// File: tb/btb_direct_tb_top.sv
`timescale 1ns/1ps
module btb_direct_tb_top;

   localparam int AW   = 32;
   localparam int NENT = 16;
   localparam int CW   = 3;
   localparam int CMAX = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_pc = '0;
   logic          upd_taken = 1'b0;
   logic [AW-1:0] upd_target = '0;
   logic          pred_hit;
   logic [AW-1:0] pred_target;
   logic          fetch_hold;
   logic          redirect_valid;
   logic [AW-1:0] redirect_pc;
   logic          squash_valid;
   logic [CW-1:0] squash_cnt;

   always #2 clk = ~clk;

   btb_direct #(.ADDR_W(AW), .ENTRIES(NENT), .IDX_LSB(2), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc),
      .pred_hit(pred_hit), .pred_target(pred_target),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
      .fetch_hold(fetch_hold), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .squash_valid(squash_valid), .squash_cnt(squash_cnt)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model
   bit            m_val [NENT];
   logic [AW-1:0] m_tgt [NENT];
   bit            p_on, p_hit;
   logic [AW-1:0] p_tgt;
   int            p_age;

   function automatic int idx_of(logic [AW-1:0] a);
      return int'(a[5:2]);
   endfunction

   function automatic logic [AW-1:0] resolve(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tgt);
      return tk ? tgt : pc + 32'd8;
   endfunction

   function automatic logic [AW-1:0] pick_pc(int n);
      case (n % 8)
         0: return 32'h0000_0100;
         1: return 32'h0000_0104;
         2: return 32'h0000_0140; // aliases 0x100
         3: return 32'h0000_0208;
         4: return 32'h0000_1108; // aliases 0x208
         5: return 32'h0000_033C;
         6: return 32'h0000_0420;
         default: return 32'h0000_0424;
      endcase
   endfunction

   function automatic logic [AW-1:0] pick_tgt(int n);
      case (n % 4)
         0: return 32'h0000_2000;
         1: return 32'h0000_2040;
         2: return 32'h0000_3F00;
         default: return 32'h0000_0010;
      endcase
   endfunction

   task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < NENT; i++) begin
         m_val[i] = 1'b0;
         m_tgt[i] = '0;
      end
      p_on = 1'b0; p_hit = 1'b0; p_tgt = '0; p_age = 0;
   endtask

   task automatic tick(bit le, logic [AW-1:0] lpc, bit ue, logic [AW-1:0] upc,
                       bit utk, logic [AW-1:0] utgt, string ovr);
      logic [AW-1:0] res;
      logic [AW-1:0] e_tgt;
      bit            e_hit, e_red, e_sq;
      int            e_cnt;
      string         t_pred, t_res;
      @(posedge clk);
      #1;
      lk_valid = le; lk_pc = lpc;
      upd_valid = ue; upd_pc = upc; upd_taken = utk; upd_target = utgt;
      res   = resolve(upc, utk, utgt);
      e_hit = le && m_val[idx_of(lpc)];
      e_tgt = e_hit ? m_tgt[idx_of(lpc)] : '0;
      if (!le)                                  t_pred = "R9";
      else if (ue && idx_of(lpc) == idx_of(upc)) t_pred = "R4";
      else if (e_hit)                           t_pred = "R2";
      else                                      t_pred = "R7";
      if (ovr != "") t_pred = ovr;
      e_red = 1'b0; e_sq = 1'b0; e_cnt = 0; t_res = "R10";
      if (ue && p_on) begin
         if (!p_hit) begin
            e_red = 1'b1; t_res = "R7";
         end else if (res != p_tgt) begin
            e_red = 1'b1; e_sq = 1'b1; t_res = "R6";
            e_cnt = (p_age > CMAX) ? CMAX : p_age;
         end else begin
            t_res = "R5";
         end
      end
      @(negedge clk);
      chk(t_pred, AW'(pred_hit), AW'(e_hit), "pred_hit");
      chk(t_pred, pred_target, e_tgt, "pred_target");
      chk("R7", AW'(fetch_hold), AW'(p_on && !p_hit), "fetch_hold");
      chk(t_res, AW'(redirect_valid), AW'(e_red), "redirect_valid");
      if (e_red) chk(t_res, redirect_pc, res, "redirect_pc");
      chk(t_res, AW'(squash_valid), AW'(e_sq), "squash_valid");
      chk(t_res, AW'(squash_cnt), AW'(e_cnt), "squash_cnt");
      if (ue) begin
         m_val[idx_of(upc)] = 1'b1;
         m_tgt[idx_of(upc)] = res;
      end
      if (le) begin
         p_on = 1'b1; p_hit = e_hit; p_tgt = e_tgt; p_age = 1;
      end else if (ue) begin
         p_on = 1'b0;
      end else if (p_on && p_age < CMAX) begin
         p_age++;
      end
   endtask

   task automatic idle();
      tick(1'b0, '0, 1'b0, '0, 1'b0, '0, "");
   endtask

   // lookup, k-1 quiet cycles, then resolution k cycles after the lookup
   task automatic branch(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tgt, int k, string ovr);
      tick(1'b1, pc, 1'b0, '0, 1'b0, '0, ovr);
      for (int j = 1; j < k; j++) idle();
      tick(1'b0, '0, 1'b1, pc, tk, tgt, "");
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      lk_valid = 1'b0; upd_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      model_clear();
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_clear();
      do_reset();

      // R8: idle outputs and every row empty after reset
      @(negedge clk);
      chk("R8", AW'(fetch_hold), '0, "fetch_hold");
      chk("R8", AW'(redirect_valid), '0, "redirect_valid");
      chk("R8", AW'(squash_valid), '0, "squash_valid");
      for (int i = 0; i < NENT; i++) tick(1'b1, AW'(i * 4), 1'b0, '0, 1'b0, '0, "R8");
      tick(1'b0, '0, 1'b1, 32'h0000_003C, 1'b1, 32'h0000_5000, "");

      // R3: not-taken records the address after the delay slot
      branch(32'h0000_0200, 1'b0, 32'h0000_7000, 2, "");
      tick(1'b1, 32'h0000_0200, 1'b0, '0, 1'b0, '0, "R3");
      tick(1'b0, '0, 1'b1, 32'h0000_0200, 1'b1, 32'h0000_0208, ""); // R5 correct guess

      // R1: aliasing through bits [5:2] and separate rows otherwise
      branch(32'h0000_0300, 1'b1, 32'h0000_0A00, 3, "");
      tick(1'b1, 32'h0000_0340, 1'b0, '0, 1'b0, '0, "R1");
      tick(1'b1, 32'h0000_0304, 1'b0, '0, 1'b0, '0, "R1");
      tick(1'b0, '0, 1'b1, 32'h0000_0304, 1'b1, 32'h0000_0B00, "");

      // R6: wrong guess after a long wait saturates the squash count
      branch(32'h0000_0300, 1'b1, 32'h0000_0C00, 10, "");
      // R6: wrong guess resolved the very next cycle
      branch(32'h0000_0300, 1'b1, 32'h0000_0D00, 1, "");

      // R4: same-row lookup and write in one cycle return old data
      tick(1'b1, 32'h0000_0600, 1'b0, '0, 1'b0, '0, "");
      tick(1'b1, 32'h0000_0300, 1'b1, 32'h0000_0340, 1'b1, 32'h0000_0E00, "R4");
      tick(1'b0, '0, 1'b1, 32'h0000_0300, 1'b1, 32'h0000_0E00, "");

      // R10: an update with nothing outstanding only writes
      idle();
      tick(1'b0, '0, 1'b1, 32'h0000_0700, 1'b1, 32'h0000_0F00, "");
      tick(1'b1, 32'h0000_0700, 1'b0, '0, 1'b0, '0, "R3");
      tick(1'b0, '0, 1'b1, 32'h0000_0700, 1'b1, 32'h0000_0F00, "");

      // random branches over an aliasing address pool
      for (int n = 0; n < 400; n++) begin
         int sel_pc, sel_tgt, k;
         bit tk;
         sel_pc  = int'($urandom_range(0, 7));
         sel_tgt = int'($urandom_range(0, 3));
         tk      = ($urandom_range(0, 3) != 0);
         k       = int'($urandom_range(1, 9));
         if ($urandom_range(0, 9) == 0) begin
            // resolution with a new lookup in the same cycle
            tick(1'b1, pick_pc(sel_pc), 1'b0, '0, 1'b0, '0, "");
            tick(1'b1, pick_pc(sel_tgt + 1), 1'b1, pick_pc(sel_pc), tk, pick_tgt(sel_tgt), "");
            tick(1'b0, '0, 1'b1, pick_pc(sel_tgt + 1), 1'b1, pick_tgt(sel_pc), "");
         end else begin
            branch(pick_pc(sel_pc), tk, pick_tgt(sel_tgt), k, "");
         end
         if (n == 200) begin
            do_reset();
            for (int i = 0; i < NENT; i++) tick(1'b1, AW'(32'h100 + i * 4), 1'b0, '0, 1'b0, '0, "R8");
            tick(1'b0, '0, 1'b1, 32'h0000_013C, 1'b1, 32'h0000_2000, "");
         end
      end

      idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule